// File: doc/BRIEF.md
# Clock Tick Generator with Power-Mode Gating

This block is the clock control unit of a small microcontroller, built entirely in one fast system clock domain. Each oscillator is represented by a single-cycle tick strobe: a digitally controlled oscillator (DCO), a high-frequency crystal, a low-power internal oscillator and a low-frequency crystal. From these strobes the block makes three tick-enable outputs: a core tick, a peripheral tick and a slow tick. Each output has its own source multiplexer and its own power-of-two divider.

Software sets up the block through a byte-wide register port: an address, a write strobe and write data. Four control bytes sit at fixed addresses with fixed reset values. A 4-bit power-control input, driven from the processor status word, selects an active mode or one of five sleep levels. The sleep level decides which outputs are held off. Downstream logic qualifies its clock with the tick outputs, so each tick must be exactly one system cycle wide and must never come early or twice.

Top module: `clkctl_unit`

## Requirements
- R1: The four control bytes sit at these addresses and reset values: DCO byte at 0x56 (reset 0x60), config A at 0x57 (reset 0x87), config B at 0x58 (reset 0x00) and config C at 0x53 (reset 0x05). A write with `reg_we` high stores `reg_wdata` at `reg_addr`. `reg_rdata` returns the byte addressed in the previous cycle, and 0x00 for any unmapped address.
- R2: Config B bits 7:6 pick the core tick source. Codes 00 and 01 select the DCO tick, 10 selects the high-frequency crystal tick and 11 selects the low-power oscillator tick.
- R3: Config B bits 5:4 set the core divider. Codes 00, 01, 10 and 11 give divide by 1, 2, 4 and 8, so the output pulses on every Nth selected source tick.
- R4: Config B bit 3 picks the peripheral tick source: 0 selects the DCO tick and 1 selects the high-frequency crystal tick. Config B bits 2:1 set its divider with the same 1/2/4/8 code.
- R5: The slow tick always counts low-frequency crystal ticks. Config A bits 5:4 set its divider with the same 1/2/4/8 code. Config A bit 6, the crystal range flag, is stored but does not change the tick count.
- R6: `lp_ctl` is laid out as {bit 3 peripheral-generator off, bit 2 DCO-generator off, bit 1 oscillator off, bit 0 core off}. The listed codes and the outputs each one stops are:
  - 0000 (active): all three outputs run.
  - 0001 (sleep 0): the core tick stops.
  - 0101 (sleep 1): the core tick stops.
  - 1001 (sleep 2): the core and peripheral ticks stop.
  - 1101 (sleep 3): the core and peripheral ticks stop.
  - 1111 (sleep 4): all three outputs stop.
- R7: Any other `lp_ctl` code is gated bit by bit. The core tick runs only when bit 0 is 0, the peripheral tick only when bit 3 is 0 and the slow tick only when bit 1 is 0. Bit 2 alone stops nothing.
- R8: A new source or divider setting takes effect only when that output's divider wraps, that is, on the tick that emits a pulse. That wrap tick is still produced with the old setting. A write that lands in the same cycle as a wrap waits for the following wrap.
- R9: Each output pulse lasts one system cycle. It appears in the cycle after the source tick that completes the count.
- R10: A read of a byte that is written in the same cycle returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the address |
| lp_ctl | input | 4 | Power-control bits from the status word |
| dco_tick | input | 1 | DCO tick strobe |
| xhi_tick | input | 1 | High-frequency crystal tick strobe |
| lpo_tick | input | 1 | Low-power oscillator tick strobe |
| xlo_tick | input | 1 | Low-frequency crystal tick strobe |
| core_tick | output | 1 | Core tick enable |
| periph_tick | output | 1 | Peripheral tick enable |
| slow_tick | output | 1 | Slow tick enable |

## Verification
A register write and a divider wrap can fall in the same cycle. This decides whether a new divider setting is applied at once or one wrap later. The bench provokes the case by raising the DCO tick in the same cycle that it writes a new core divider while the divide-by-1 setting is active. It expects two further undivided pulses before the new ratio shows. A second case changes the divider mid-count and checks that the running count still completes at the old ratio.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int REG_W  = 8;
   localparam int ADDR_W = 8;
   localparam int NREG   = 4;

   // register slot indices
   localparam int IDX_DCO  = 0;
   localparam int IDX_CFGA = 1;
   localparam int IDX_CFGB = 2;
   localparam int IDX_CFGC = 3;

   // slot i occupies bits [i*8 +: 8]
   localparam logic [NREG*ADDR_W-1:0] ADDR_MAP = {8'h53, 8'h58, 8'h57, 8'h56};
   localparam logic [NREG*REG_W-1:0]  RST_MAP  = {8'h05, 8'h00, 8'h87, 8'h60};

   // power-control bit positions
   localparam int LP_CPU  = 0;
   localparam int LP_OSC  = 1;
   localparam int LP_GEN0 = 2;
   localparam int LP_GEN1 = 3;

   typedef enum logic [2:0] {
      PM_RUN   = 3'd0,
      PM_NAP0  = 3'd1,
      PM_NAP1  = 3'd2,
      PM_NAP2  = 3'd3,
      PM_NAP3  = 3'd4,
      PM_NAP4  = 3'd5,
      PM_MIXED = 3'd6
   } pm_e;

   typedef struct packed {
      logic core;
      logic periph;
      logic slow;
   } run_t;

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int NREG   = 4,
   parameter logic [NREG*ADDR_W-1:0] AMAP = '0,
   parameter logic [NREG*DATA_W-1:0] RMAP = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic                   we_i,
   input  logic [DATA_W-1:0]      wdata_i,
   output logic [DATA_W-1:0]      rdata_o,
   output logic [NREG*DATA_W-1:0] regs_o
);

   if (NREG < 1) begin : g_bad_nreg
      $error("clkctl_regs: NREG must be at least 1");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("clkctl_regs: widths must be positive");
   end

   logic [NREG-1:0]   hit;
   logic [DATA_W-1:0] rd_mux;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      assign hit[i] = (addr_i == AMAP[i*ADDR_W +: ADDR_W]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RMAP[i*DATA_W +: DATA_W];
         else if (we_i && hit[i])
            q <= wdata_i;
      end
      assign regs_o[i*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i])
            rd_mux = rd_mux | regs_o[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_o <= '0;
      else
         rdata_o <= rd_mux;
   end

endmodule

// File: rtl/clkctl_pwr_decode.sv
module clkctl_pwr_decode
   import clkctl_pkg::*;
(
   input  logic [3:0] lp_i,
   output run_t       run_o
);

   pm_e mode;

   always_comb begin
      unique case (lp_i)
         4'b0000: mode = PM_RUN;
         4'b0001: mode = PM_NAP0;
         4'b0101: mode = PM_NAP1;
         4'b1001: mode = PM_NAP2;
         4'b1101: mode = PM_NAP3;
         4'b1111: mode = PM_NAP4;
         default: mode = PM_MIXED;
      endcase
   end

   always_comb begin
      case (mode)
         PM_RUN:  run_o = '{core: 1'b1, periph: 1'b1, slow: 1'b1};
         PM_NAP0,
         PM_NAP1: run_o = '{core: 1'b0, periph: 1'b1, slow: 1'b1};
         PM_NAP2,
         PM_NAP3: run_o = '{core: 1'b0, periph: 1'b0, slow: 1'b1};
         PM_NAP4: run_o = '{core: 1'b0, periph: 1'b0, slow: 1'b0};
         default: run_o = '{core:   !lp_i[LP_CPU],
                            periph: !lp_i[LP_GEN1],
                            slow:   !lp_i[LP_OSC]};
      endcase
   end

endmodule

// File: rtl/clkctl_tick_div.sv
module clkctl_tick_div #(
   parameter int SEL_W = 2,
   parameter int DIV_W = 2,
   parameter logic [SEL_W-1:0] RST_SEL = '0,
   parameter logic [DIV_W-1:0] RST_DIV = '0,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<SEL_W)-1:0] src_i,
   input  logic [SEL_W-1:0]      sel_i,
   input  logic [DIV_W-1:0]      div_i,
   input  logic                  run_i,
   output logic                  tick_o
);

   localparam int CNT_W = (1 << DIV_W) - 1;

   if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
      $error("clkctl_tick_div: DIV_W must lie in 1..4");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("clkctl_tick_div: SEL_W must lie in 1..4");
   end

   logic [SEL_W-1:0] act_sel;
   logic [DIV_W-1:0] act_div;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             src_hit;
   logic             at_end;
   logic             fire;

   // terminal count is 2**act_div - 1: a run of ones
   always_comb begin
      lim = '0;
      for (int b = 0; b < CNT_W; b++)
         lim[b] = (b < int'(act_div));
   end

   assign src_hit = src_i[act_sel];
   assign at_end  = (cnt == lim);
   assign fire    = run_i & src_hit & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         act_sel <= RST_SEL;
         act_div <= RST_DIV;
      end else if (run_i && src_hit) begin
         if (at_end) begin
            cnt     <= '0;
            act_sel <= sel_i;
            act_div <= div_i;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end

   if (REG_OUT) begin : g_reg_out
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tick_q <= 1'b0;
         else
            tick_q <= fire;
      end
      assign tick_o = tick_q;
   end else begin : g_comb_out
      assign tick_o = fire;
   end

endmodule

// File: rtl/clkctl_unit.sv
module clkctl_unit
   import clkctl_pkg::*;
#(
   parameter int DIV_W    = 2,
   parameter bit TICK_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [3:0]        lp_ctl,
   input  logic              dco_tick,
   input  logic              xhi_tick,
   input  logic              lpo_tick,
   input  logic              xlo_tick,
   output logic              core_tick,
   output logic              periph_tick,
   output logic              slow_tick
);

   // field positions inside config B / config A
   localparam int CORE_SEL_LSB = 6;
   localparam int CORE_DIV_LSB = 4;
   localparam int PER_SEL_BIT  = 3;
   localparam int PER_DIV_LSB  = 1;
   localparam int SLOW_DIV_LSB = 4;

   if (CORE_DIV_LSB + DIV_W > CORE_SEL_LSB || PER_DIV_LSB + DIV_W > PER_SEL_BIT) begin : g_bad_layout
      $error("clkctl_unit: DIV_W does not fit the control byte layout");
   end

   logic [NREG*REG_W-1:0] regs;
   logic [REG_W-1:0]      cfg_a;
   logic [REG_W-1:0]      cfg_b;
   run_t                  run;

   clkctl_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (REG_W),
      .NREG   (NREG),
      .AMAP   (ADDR_MAP),
      .RMAP   (RST_MAP)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (reg_addr),
      .we_i    (reg_we),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .regs_o  (regs)
   );

   assign cfg_a = regs[IDX_CFGA*REG_W +: REG_W];
   assign cfg_b = regs[IDX_CFGB*REG_W +: REG_W];

   clkctl_pwr_decode u_pwr (
      .lp_i  (lp_ctl),
      .run_o (run)
   );

   // core: codes 0 and 1 both pick the DCO
   clkctl_tick_div #(
      .SEL_W   (2),
      .DIV_W   (DIV_W),
      .RST_SEL (RST_MAP[IDX_CFGB*REG_W + CORE_SEL_LSB +: 2]),
      .RST_DIV (RST_MAP[IDX_CFGB*REG_W + CORE_DIV_LSB +: DIV_W]),
      .REG_OUT (TICK_REG)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  ({lpo_tick, xhi_tick, dco_tick, dco_tick}),
      .sel_i  (cfg_b[CORE_SEL_LSB +: 2]),
      .div_i  (cfg_b[CORE_DIV_LSB +: DIV_W]),
      .run_i  (run.core),
      .tick_o (core_tick)
   );

   clkctl_tick_div #(
      .SEL_W   (1),
      .DIV_W   (DIV_W),
      .RST_SEL (RST_MAP[IDX_CFGB*REG_W + PER_SEL_BIT]),
      .RST_DIV (RST_MAP[IDX_CFGB*REG_W + PER_DIV_LSB +: DIV_W]),
      .REG_OUT (TICK_REG)
   ) u_periph (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  ({xhi_tick, dco_tick}),
      .sel_i  (cfg_b[PER_SEL_BIT]),
      .div_i  (cfg_b[PER_DIV_LSB +: DIV_W]),
      .run_i  (run.periph),
      .tick_o (periph_tick)
   );

   // slow: single source, selector tied low
   clkctl_tick_div #(
      .SEL_W   (1),
      .DIV_W   (DIV_W),
      .RST_SEL (1'b0),
      .RST_DIV (RST_MAP[IDX_CFGA*REG_W + SLOW_DIV_LSB +: DIV_W]),
      .REG_OUT (TICK_REG)
   ) u_slow (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  ({xlo_tick, xlo_tick}),
      .sel_i  (1'b0),
      .div_i  (cfg_a[SLOW_DIV_LSB +: DIV_W]),
      .run_i  (run.slow),
      .tick_o (slow_tick)
   );

   // bytes held for software but not decoded here
   logic unused_cfg;
   assign unused_cfg = ^{regs[IDX_DCO*REG_W +: REG_W], regs[IDX_CFGC*REG_W +: REG_W],
                         cfg_a, cfg_b};

endmodule

// File: rtl/clkctl_unit_chk.sv
module clkctl_unit_chk
   import clkctl_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic [3:0]        lp_ctl,
   input logic              dco_tick,
   input logic              xhi_tick,
   input logic              lpo_tick,
   input logic              xlo_tick,
   input logic              core_tick,
   input logic              periph_tick,
   input logic              slow_tick
);

   localparam logic [ADDR_W-1:0] CFGB_ADDR = ADDR_MAP[IDX_CFGB*ADDR_W +: ADDR_W];

   AST_CORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      lp_ctl[LP_CPU] |=> !core_tick); // R6

   AST_PERIPH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      lp_ctl[LP_GEN1] |=> !periph_tick); // R6

   AST_SLOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      lp_ctl[LP_OSC] |=> !slow_tick); // R7

   AST_CORE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      core_tick |-> $past(dco_tick || xhi_tick || lpo_tick)); // R2

   AST_PERIPH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      periph_tick |-> $past(dco_tick || xhi_tick)); // R4

   AST_SLOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      slow_tick |-> $past(xlo_tick)); // R5

   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == CFGB_ADDR) ##1 (!reg_we && reg_addr == CFGB_ADDR)
      |=> reg_rdata == $past(reg_wdata, 2)); // R1

endmodule

bind clkctl_unit clkctl_unit_chk u_chk (.*);

// File: tb/clkctl_unit_bench.sv
`timescale 1ns/1ps
module clkctl_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [3:0] lp_ctl = '0;
   logic       dco_tick = 1'b0, xhi_tick = 1'b0, lpo_tick = 1'b0, xlo_tick = 1'b0;
   logic       core_tick, periph_tick, slow_tick;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   clkctl_unit u_clkctl_unit (.*);

   // {cfg_b, cfg_a, lp_ctl, core count, periph count, slow count} over 48 cycles
   // sources: dco every cycle (48), xhi every 2nd (24), lpo every 4th (12), xlo every 3rd (16)
   localparam int NVEC = 14;
   localparam logic [43:0] VEC [NVEC] = '{
      {8'h00, 8'h87, 4'h0, 8'd48, 8'd48, 8'd16},  // reset config, active
      {8'h9C, 8'hB7, 4'h0, 8'd12, 8'd6,  8'd2 },  // xhi/2, xhi/4, /8
      {8'hC6, 8'hD7, 4'h1, 8'd0,  8'd6,  8'd8 },  // sleep 0, range flag set
      {8'h7A, 8'hA7, 4'h5, 8'd0,  8'd12, 8'd4 },  // sleep 1
      {8'h00, 8'h87, 4'h9, 8'd0,  8'd0,  8'd16},  // sleep 2
      {8'h00, 8'h87, 4'hD, 8'd0,  8'd0,  8'd16},  // sleep 3
      {8'h00, 8'h87, 4'hF, 8'd0,  8'd0,  8'd0 },  // sleep 4
      {8'h00, 8'h87, 4'h2, 8'd48, 8'd48, 8'd0 },  // unlisted: osc off
      {8'h00, 8'h87, 4'h8, 8'd48, 8'd0,  8'd16},  // unlisted: periph-gen off
      {8'h00, 8'h87, 4'h4, 8'd48, 8'd48, 8'd16},  // unlisted: bit 2 alone
      {8'h00, 8'h87, 4'hB, 8'd0,  8'd0,  8'd0 },  // unlisted: 1011
      {8'hE0, 8'h87, 4'h0, 8'd3,  8'd48, 8'd16},  // lpo/4
      {8'h50, 8'h87, 4'h0, 8'd24, 8'd48, 8'd16},  // code 01 -> dco, /2
      {8'hB4, 8'h87, 4'h0, 8'd3,  8'd12, 8'd16}   // xhi/8, dco/4
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_we = 1'b0; lp_ctl = '0;
      dco_tick = 0; xhi_tick = 0; lpo_tick = 0; xlo_tick = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      @(negedge clk);
      chk(tag, int'(reg_rdata), exp);
   endtask

   // one DCO tick, optional config B write in the same cycle, then check core pulse
   task automatic dco_step(input bit do_wr, input logic [7:0] d, input int exp, input string tag);
      @(negedge clk);
      dco_tick = 1'b1;
      if (do_wr) begin reg_we = 1'b1; reg_addr = 8'h58; reg_wdata = d; end
      @(negedge clk);
      dco_tick = 1'b0; reg_we = 1'b0;
      chk(tag, int'(core_tick), exp);
   endtask

   task automatic run_window(input int n, output int cc, output int cp, output int cs);
      cc = 0; cp = 0; cs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cc += int'(core_tick); cp += int'(periph_tick); cs += int'(slow_tick);
         dco_tick = 1'b1;
         xhi_tick = (i % 2 == 0);
         lpo_tick = (i % 4 == 0);
         xlo_tick = (i % 3 == 0);
      end
      @(negedge clk);
      cc += int'(core_tick); cp += int'(periph_tick); cs += int'(slow_tick);
      dco_tick = 0; xhi_tick = 0; lpo_tick = 0; xlo_tick = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int cc, cp, cs;
      // reset state
      do_reset();
      chk("R9 reset core_tick", int'(core_tick), 0);
      chk("R9 reset periph_tick", int'(periph_tick), 0);
      chk("R9 reset slow_tick", int'(slow_tick), 0);
      rd_chk(8'h56, 8'h60, "R1 reset DCO byte");
      rd_chk(8'h57, 8'h87, "R1 reset config A");
      rd_chk(8'h58, 8'h00, "R1 reset config B");
      rd_chk(8'h53, 8'h05, "R1 reset config C");
      rd_chk(8'h00, 8'h00, "R1 unmapped read");

      // vector table: configuration, power mode, tick counts
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         wr(8'h58, VEC[v][43:36]);
         wr(8'h57, VEC[v][35:28]);
         @(negedge clk);                 // prime: one wrap on every divider loads config
         dco_tick = 1; xhi_tick = 1; lpo_tick = 1; xlo_tick = 1;
         @(negedge clk);
         dco_tick = 0; xhi_tick = 0; lpo_tick = 0; xlo_tick = 0;
         lp_ctl = VEC[v][27:24];
         run_window(48, cc, cp, cs);
         chk($sformatf("R2 R3 R6 R7 vec%0d core count", v), cc, int'(VEC[v][23:16]));
         chk($sformatf("R4 R6 R7 vec%0d periph count", v), cp, int'(VEC[v][15:8]));
         chk($sformatf("R5 R6 R7 vec%0d slow count", v), cs, int'(VEC[v][7:0]));
      end

      // register writes and read-back
      do_reset();
      wr(8'h53, 8'hA5);
      rd_chk(8'h53, 8'hA5, "R1 config C read-back");
      wr(8'h56, 8'h3C);
      rd_chk(8'h56, 8'h3C, "R1 DCO byte read-back");

      // read during write returns old value
      @(negedge clk);
      reg_addr = 8'h53; reg_we = 1'b1; reg_wdata = 8'h11;
      @(negedge clk);
      reg_we = 1'b0;
      chk("R10 read during write old value", int'(reg_rdata), 8'hA5);
      @(negedge clk);
      chk("R10 read after write new value", int'(reg_rdata), 8'h11);

      // single-cycle pulse, one cycle after source tick
      do_reset();
      @(negedge clk);
      dco_tick = 1'b1;
      chk("R9 no pulse in tick cycle", int'(core_tick), 0);
      @(negedge clk);
      dco_tick = 1'b0;
      chk("R9 core pulse next cycle", int'(core_tick), 1);
      chk("R9 periph pulse next cycle", int'(periph_tick), 1);
      @(negedge clk);
      chk("R9 core pulse one cycle wide", int'(core_tick), 0);

      // write in same cycle as a wrap: applies one wrap later
      do_reset();
      dco_step(1'b1, 8'h10, 1, "R8 collision tick A old /1");
      dco_step(1'b0, 8'h00, 1, "R8 collision tick B still /1");
      dco_step(1'b0, 8'h00, 0, "R8 collision tick C now /2");
      dco_step(1'b0, 8'h00, 1, "R8 collision tick D /2 wrap");

      // change mid-count: running count completes at old ratio
      do_reset();
      wr(8'h58, 8'h20);
      dco_step(1'b0, 8'h00, 1, "R8 prime loads /4");
      dco_step(1'b0, 8'h00, 0, "R8 count 1 of 4");
      wr(8'h58, 8'h00);
      dco_step(1'b0, 8'h00, 0, "R8 count 2 of 4 after write");
      dco_step(1'b0, 8'h00, 0, "R8 count 3 of 4 after write");
      dco_step(1'b0, 8'h00, 1, "R8 wrap at old /4");
      dco_step(1'b0, 8'h00, 1, "R8 new /1 in effect");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule